// File: doc/BRIEF.md
# Three-Wire Serial Word EEPROM Slave

This block is a synthesizable behavioural model of a small non-volatile word store. The store is reached over a three-wire serial bus made of a chip select, a serial clock and a data input, with a data output and a separate output enable. All four bus pins are sampled in the system clock domain through synchronisers. Bus edges are found from the sampled values, so the serial clock must be several system clocks slower than `clk`. The array holds `2**ADDR_W` words of 16 bits each. `ADDR_W` ranges from 6 to 9.

A host raises chip select and clocks in a frame: a start bit, a two-bit opcode and an address field. A frame may also carry 16 data bits. Reads stream words out with an address that keeps incrementing. Writes go through a write-enable latch and a program-enable pin. Each write then runs a self-timed programming cycle whose length is a cycle-count parameter. While chip select is high after a programming cycle has begun, the data output reports busy or ready.

Top module: `mw_eeprom`

## Requirements
- R1: A frame is a start bit 1, then a 2-bit opcode, then an address field, all sampled on serial-clock rising edges, most significant bit first. Opcode 10 is READ, 01 is WRITE and 00 is the extended group. In the extended group the two top field bits select the command: 11 sets the write-enable latch, 00 clears it, and 01 is the factory fill-all command. The field is ADDR_W bits wide, or ADDR_W+1 bits when ADDR_W is 7 or 9. The address is the low ADDR_W bits of the field.
- R2: Zeros clocked in while chip select is high and no frame is open are ignored, so both "1" and "01" open a frame.
- R3: On READ, the serial-clock edge that samples the last address bit drives the output enable high and puts a dummy 0 on the data output. Each following rising edge presents the next bit of the addressed word, from bit 15 down to bit 0.
- R4: While the serial clock keeps running in a READ, the address increments after every 16 bits and wraps from the top address to 0.
- R5: A WRITE takes 16 data bits after the field. Programming starts on the chip-select fall that follows the last data bit. A further serial-clock rise before that fall cancels the write.
- R6: The write-enable latch is clear after reset. A WRITE does nothing while the latch is clear. READ works whatever the latch state.
- R7: With chip select high after programming has started, the output enable is high. The data output is 0 while programming runs and 1 once the word has been stored.
- R8: The busy/ready status survives chip-select low periods. It stays on the output until the start bit of the next accepted frame.
- R9: The output enable is low whenever chip select is low. It is also low when neither read data nor status is being presented.
- R10: The fill-all command is accepted with its 16 data bits, but it changes no word and starts no programming cycle.
- R11: While the program-enable input is low, WRITE and both latch commands have no effect.
- R12: Frames that start while programming is in progress are ignored. Status stays on the output during such a frame.
- R13: Chip select falling in the middle of a frame discards that frame with no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data in |
| pe_i | input | 1 | Program enable; low blocks WRITE and the latch commands |
| do_o | output | 1 | Serial data out: read bits or busy/ready |
| do_oe_o | output | 1 | Output enable for do_o; low means high impedance |

## Verification
The hardest state to reach is a frame that arrives while a programming cycle is still running. The host must drop chip select to start programming. It then has to raise it again and clock a complete latch-clear frame before the countdown expires. The bench does this with a shortened programming time. It checks that status stays on the output during that frame. It then shows through a later write that the latch was never cleared. The cancelled write, which needs exactly one extra serial-clock rise between the last data bit and the chip-select fall, is produced by the same bit-level task that drives normal frames.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADR,
        ST_DAT,
        ST_WAITCS,
        ST_RD,
        ST_SKIP
    } mw_state_e;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;

    localparam logic [1:0] EXT_LOCK   = 2'b00;
    localparam logic [1:0] EXT_FILL   = 2'b01;
    localparam logic [1:0] EXT_UNLOCK = 2'b11;

    // Serial field width: one extra leading bit for 7- and 9-bit addresses
    function automatic int fld_width(input int aw);
        if (aw == 7 || aw == 9) return aw + 1;
        return aw;
    endfunction

endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q[s] <= '0;
                end else if (s == 0) begin
                    stg_q[s] <= pins_i;
                end else begin
                    stg_q[s] <= stg_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [WORD_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int PROG_CYCLES = 2000,
    parameter int ADDR_W      = 6,
    parameter int WORD_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] data_i,
    output logic              busy_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic [WORD_W-1:0] wdata_o
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0]     cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if (start_i) begin
            cnt_q  <= CW'(PROG_CYCLES);
            addr_q <= addr_i;
            data_q <= data_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o  = (cnt_q != '0);
    assign we_o    = (cnt_q == CW'(1));
    assign waddr_o = addr_q;
    assign wdata_o = data_q;
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
    parameter int ADDR_W      = 6,
    parameter int PROG_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    input  logic pe_i,
    output logic do_o,
    output logic do_oe_o
);
    import mw_pkg::*;

    localparam int FIELD_W = fld_width(ADDR_W);
    localparam int CNT_W   = $clog2(WORD_W + 1);

    typedef struct packed {
        mw_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [1:0]         op;
        logic [FIELD_W-1:0] fld;
        logic [WORD_W-1:0]  sh;
        logic [ADDR_W-1:0]  addr;
        logic               wen;
        logic               show;
        logic               dout;
        logic               wr_ok;
        logic               sk_prev;
        logic               cs_prev;
    } regs_t;

    regs_t r_q, r_d;

    logic [3:0]         pins_s;
    logic               cs_s, sk_s, di_s, pe_s;
    logic               sk_rise, cs_fall;
    logic [FIELD_W-1:0] fld_shift;
    logic [ADDR_W-1:0]  rd_addr;
    logic [WORD_W-1:0]  rdata;
    logic               start_prog, busy, arr_we;
    logic [ADDR_W-1:0]  arr_waddr;
    logic [WORD_W-1:0]  arr_wdata;
    mw_state_e          st_q;
    logic               wen_q;

    mw_pin_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i ({pe_i, di_i, sk_i, cs_i}),
        .sync_o (pins_s)
    );

    assign cs_s    = pins_s[0];
    assign sk_s    = pins_s[1];
    assign di_s    = pins_s[2];
    assign pe_s    = pins_s[3];
    assign sk_rise = sk_s & ~r_q.sk_prev;
    assign cs_fall = r_q.cs_prev & ~cs_s;
    assign st_q    = r_q.st;
    assign wen_q   = r_q.wen;

    always_comb begin
        fld_shift = {r_q.fld[FIELD_W-2:0], di_s};
        rd_addr   = (r_q.st == ST_ADR) ? fld_shift[ADDR_W-1:0] : r_q.addr + 1'b1;
    end

    mw_word_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (arr_we),
        .waddr_i (arr_waddr),
        .wdata_i (arr_wdata),
        .raddr_i (rd_addr),
        .rdata_o (rdata)
    );

    mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_prog),
        .addr_i  (r_q.addr),
        .data_i  (r_q.sh),
        .busy_o  (busy),
        .we_o    (arr_we),
        .waddr_o (arr_waddr),
        .wdata_o (arr_wdata)
    );

    always_comb begin
        r_d        = r_q;
        start_prog = 1'b0;
        r_d.sk_prev = sk_s;
        r_d.cs_prev = cs_s;

        if (!cs_s) begin
            // Deselect: only a completed, permitted write survives it
            if (r_q.st == ST_WAITCS && cs_fall && r_q.wr_ok && !busy) begin
                start_prog = 1'b1;
                r_d.show   = 1'b1;
            end
            r_d.st    = ST_IDLE;
            r_d.cnt   = '0;
            r_d.wr_ok = 1'b0;
        end else if (sk_rise) begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (di_s) begin
                        if (busy) begin
                            r_d.st = ST_SKIP;
                        end else begin
                            r_d.st   = ST_OPC;
                            r_d.cnt  = '0;
                            r_d.show = 1'b0;
                        end
                    end
                end
                ST_OPC: begin
                    r_d.op  = {r_q.op[0], di_s};
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_W'(1)) begin
                        r_d.st  = ST_ADR;
                        r_d.cnt = '0;
                    end
                end
                ST_ADR: begin
                    r_d.fld = fld_shift;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_W'(FIELD_W - 1)) begin
                        r_d.cnt  = '0;
                        r_d.addr = fld_shift[ADDR_W-1:0];
                        r_d.st   = ST_SKIP;
                        case (r_q.op)
                            OP_READ: begin
                                r_d.st   = ST_RD;
                                r_d.sh   = rdata;
                                r_d.dout = 1'b0;
                            end
                            OP_WRITE: begin
                                r_d.st    = ST_DAT;
                                r_d.wr_ok = r_q.wen & pe_s;
                            end
                            OP_EXT: begin
                                case (fld_shift[FIELD_W-1 -: 2])
                                    EXT_UNLOCK: if (pe_s) r_d.wen = 1'b1;
                                    EXT_LOCK:   if (pe_s) r_d.wen = 1'b0;
                                    EXT_FILL: begin
                                        r_d.st    = ST_DAT;
                                        r_d.wr_ok = 1'b0;
                                    end
                                    default: ;
                                endcase
                            end
                            default: ;
                        endcase
                    end
                end
                ST_DAT: begin
                    r_d.sh  = {r_q.sh[WORD_W-2:0], di_s};
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_W'(WORD_W - 1)) begin
                        r_d.st  = ST_WAITCS;
                        r_d.cnt = '0;
                    end
                end
                ST_WAITCS: begin
                    r_d.st    = ST_SKIP;
                    r_d.wr_ok = 1'b0;
                end
                ST_RD: begin
                    r_d.dout = r_q.sh[WORD_W-1];
                    r_d.sh   = {r_q.sh[WORD_W-2:0], 1'b0};
                    r_d.cnt  = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_W'(WORD_W - 1)) begin
                        r_d.cnt  = '0;
                        r_d.addr = r_q.addr + 1'b1;
                        r_d.sh   = rdata;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        do_oe_o = 1'b0;
        do_o    = 1'b0;
        if (cs_s) begin
            if (r_q.st == ST_RD) begin
                do_oe_o = 1'b1;
                do_o    = r_q.dout;
            end else if (r_q.show && (r_q.st == ST_IDLE || r_q.st == ST_SKIP)) begin
                do_oe_o = 1'b1;
                do_o    = ~busy;
            end
        end
    end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_s,
    input logic              cs_fall,
    input logic              busy,
    input logic              wen,
    input logic              pe_s,
    input mw_pkg::mw_state_e st,
    input logic              do_o,
    input logic              do_oe_o
);
    import mw_pkg::*;

    p_dark_when_deselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |-> !do_oe_o);

    p_dummy_leads_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(do_oe_o) && st == ST_RD) |-> !do_o);

    p_prog_on_cs_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_fall));

    p_prog_needs_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wen));

    p_latch_needs_pe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wen) |-> $past(pe_s));

    p_no_frame_while_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(st inside {ST_OPC, ST_ADR, ST_DAT}));
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s    (cs_s),
    .cs_fall (cs_fall),
    .busy    (busy),
    .wen     (wen_q),
    .pe_s    (pe_s),
    .st      (st_q),
    .do_o    (do_o),
    .do_oe_o (do_oe_o)
);

// File: tb/sim_mw_eeprom.sv
module sim_mw_eeprom;
    localparam int ADDR_W  = 6;
    localparam int FIELD_W = 6;
    localparam int PROG    = 400;
    localparam int NV      = 8;

    // {address, data} pairs written then read back
    localparam logic [21:0] VEC [NV] = '{
        {6'd0,  16'hA5C3}, {6'd1,  16'h0001}, {6'd2,  16'h8000}, {6'd7,  16'hFFFF},
        {6'd21, 16'h5A5A}, {6'd42, 16'h1357}, {6'd62, 16'hC0DE}, {6'd63, 16'h2468}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_i = 1'b0, sk_i = 1'b0, di_i = 1'b0, pe_i = 1'b1;
    logic do_o, do_oe_o;

    int   errors = 0;
    int   checks = 0;
    logic last_do, last_oe;
    logic [15:0] rd_buf [2];
    logic        dummy_do, dummy_oe;
    logic        saw_busy, saw_ready;

    always #5 clk = ~clk;

    mw_eeprom #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sk_i(sk_i), .di_i(di_i),
        .pe_i(pe_i), .do_o(do_o), .do_oe_o(do_oe_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bit_io(input logic b);
        di_i = b;
        repeat (4) @(negedge clk);
        sk_i = 1'b1;
        repeat (4) @(negedge clk);
        sk_i = 1'b0;
        last_do = do_o;
        last_oe = do_oe_o;
    endtask

    task automatic begin_frame();
        cs_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic end_frame();
        cs_i = 1'b0;
        di_i = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [FIELD_W-1:0] fld);
        bit_io(1'b1);
        bit_io(op[1]);
        bit_io(op[0]);
        for (int i = FIELD_W - 1; i >= 0; i--) bit_io(fld[i]);
    endtask

    task automatic command(input logic [1:0] op, input logic [FIELD_W-1:0] fld);
        begin_frame();
        send_hdr(op, fld);
        end_frame();
    endtask

    task automatic wait_ready();
        cs_i = 1'b1;
        repeat (6) @(negedge clk);
        saw_busy = do_oe_o && !do_o;
        for (int i = 0; i < 4 * PROG; i++) begin
            if (do_oe_o && do_o) break;
            @(negedge clk);
        end
        saw_ready = do_oe_o && do_o;
        end_frame();
    endtask

    task automatic write_word(input logic [5:0] a, input logic [15:0] d, input bit wait_it);
        begin_frame();
        send_hdr(2'b01, a);
        for (int i = 15; i >= 0; i--) bit_io(d[i]);
        end_frame();
        if (wait_it) wait_ready();
    endtask

    task automatic read_words(input logic [5:0] a, input int n);
        begin_frame();
        send_hdr(2'b10, a);
        dummy_do = last_do;
        dummy_oe = last_oe;
        for (int w = 0; w < n; w++) begin
            for (int i = 15; i >= 0; i--) begin
                bit_io(1'b0);
                rd_buf[w][i] = last_do;
            end
        end
        end_frame();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got %h expected %h", 0, 1);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 reset output disabled", do_oe_o, 0);
        begin_frame();
        chk("R9 selected but idle", do_oe_o, 0);
        end_frame();

        // Write with latch clear: nothing happens
        write_word(6'd5, 16'h1234, 0);
        begin_frame();
        chk("R6 no status after locked write", do_oe_o, 0);
        end_frame();
        read_words(6'd5, 1);
        chk("R3 dummy bit value", dummy_do, 0);
        chk("R3 dummy bit enabled", dummy_oe, 1);
        chk("R6 locked write left word", rd_buf[0], 16'h0000);

        // Unlock with two leading zeros
        begin_frame();
        bit_io(1'b0);
        bit_io(1'b0);
        send_hdr(2'b00, 6'b110000);
        end_frame();

        for (int v = 0; v < NV; v++) begin
            write_word(VEC[v][21:16], VEC[v][15:0], 1);
            chk("R7 busy seen", saw_busy, 1);
            chk("R7 ready seen", saw_ready, 1);
            read_words(VEC[v][21:16], 1);
            chk("R5 R1 readback", rd_buf[0], VEC[v][15:0]);
        end
        chk("R2 leading zeros still unlocked", saw_ready, 1);

        read_words(6'd63, 2);
        chk("R4 word at top", rd_buf[0], 16'h2468);
        chk("R4 wrap to 0", rd_buf[1], 16'hA5C3);
        read_words(6'd1, 2);
        chk("R4 increment", rd_buf[1], 16'h8000);

        // Status persists across deselect until a start bit
        write_word(6'd10, 16'h0F0F, 1);
        begin_frame();
        chk("R8 status after reselect oe", do_oe_o, 1);
        chk("R8 status after reselect ready", do_o, 1);
        bit_io(1'b0);
        chk("R8 status across leading zero", last_oe, 1);
        bit_io(1'b1);
        chk("R8 start bit clears status", last_oe, 0);
        bit_io(1'b1);
        bit_io(1'b0);
        for (int i = FIELD_W - 1; i >= 0; i--) bit_io(6'd10 >> i);
        for (int i = 15; i >= 0; i--) begin
            bit_io(1'b0);
            rd_buf[0][i] = last_do;
        end
        end_frame();
        chk("R8 read after status", rd_buf[0], 16'h0F0F);

        // Extra clock before CS fall cancels the write
        begin_frame();
        send_hdr(2'b01, 6'd11);
        for (int i = 15; i >= 0; i--) bit_io(i[0]);
        bit_io(1'b0);
        end_frame();
        begin_frame();
        chk("R5 cancelled write no status", do_oe_o, 0);
        end_frame();
        read_words(6'd11, 1);
        chk("R5 cancelled write no change", rd_buf[0], 16'h0000);

        // Fill-all: accepted, no effect
        begin_frame();
        send_hdr(2'b00, 6'b010000);
        for (int i = 15; i >= 0; i--) bit_io(1'b1);
        end_frame();
        begin_frame();
        chk("R10 fill-all no status", do_oe_o, 0);
        end_frame();
        read_words(6'd0, 1);
        chk("R10 fill-all no change", rd_buf[0], 16'hA5C3);

        // Lock frame while busy is ignored
        write_word(6'd12, 16'h3333, 0);
        begin_frame();
        bit_io(1'b1);
        chk("R12 status held during frame", {last_oe, last_do}, 2'b10);
        bit_io(1'b0);
        bit_io(1'b0);
        for (int i = FIELD_W - 1; i >= 0; i--) bit_io(1'b0);
        end_frame();
        wait_ready();
        write_word(6'd13, 16'h4444, 1);
        read_words(6'd13, 1);
        chk("R12 lock during busy ignored", rd_buf[0], 16'h4444);

        // Program-enable low
        pe_i = 1'b0;
        command(2'b00, 6'b000000);
        pe_i = 1'b1;
        write_word(6'd14, 16'h5555, 1);
        read_words(6'd14, 1);
        chk("R11 lock blocked by pe", rd_buf[0], 16'h5555);
        pe_i = 1'b0;
        write_word(6'd15, 16'h6666, 0);
        begin_frame();
        chk("R11 write blocked no status", do_oe_o, 0);
        end_frame();
        read_words(6'd15, 1);
        chk("R11 write blocked no change", rd_buf[0], 16'h0000);
        pe_i = 1'b1;

        // Abort mid-frame
        begin_frame();
        send_hdr(2'b01, 6'd16);
        for (int i = 0; i < 8; i++) bit_io(1'b1);
        end_frame();
        begin_frame();
        chk("R13 aborted write no status", do_oe_o, 0);
        end_frame();
        read_words(6'd16, 1);
        chk("R13 aborted write no change", rd_buf[0], 16'h0000);

        // Lock, then write ignored, read still works
        command(2'b00, 6'b000000);
        write_word(6'd17, 16'h7777, 0);
        read_words(6'd17, 1);
        chk("R6 write after lock ignored", rd_buf[0], 16'h0000);
        read_words(6'd21, 1);
        chk("R6 read while locked", rd_buf[0], 16'h5A5A);
        chk("R9 idle after frames", do_oe_o, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule